// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Deferred Updates

This block holds two independent pulse-width modulator channels. Each channel has a 16-bit period, a 16-bit duty value and a polarity bit, all loaded through one shared register write port. A channel counts only on cycles where its own clock-enable input is high, so each output can run from a different rate derived from the system clock.

Settings written to a stopped channel become live at once. Settings written to a running channel are parked in a shadow copy and go live only when the counter wraps at the end of the current PWM cycle. The output therefore never shows a pulse built from a mix of old and new values. A channel in synchronous mode does not start counting when it is enabled. It waits for a rising edge on a shared external start input, so several channels, or several instances of the block, can begin in step.

Top module: `pwm_dual`

## Requirements
- R1: After reset both outputs are low, both channels are stopped, and every period, duty and polarity setting is zero.
- R2: A stopped channel, and one armed and waiting for its start edge, drives its inactive level. That level equals the channel's polarity bit: 0 means active high and 1 means active low.
- R3: A write uses the register select code to pick the field: 0 is period, 1 is duty, 2 is polarity (taken from data bit 0), and code 3 changes nothing. The channel number picks which channel is written. A write to a stopped channel shows on the output from the next cycle.
- R4: A running channel's counter advances by one only on cycles where its clock enable is high. It counts from 0 up to the period value, wraps to 0, and drives the active level while the count is less than the duty value. A PWM cycle therefore lasts period+1 enabled cycles.
- R5: A duty value of 0 gives a constant inactive level. A duty value greater than the period gives a constant active level.
- R6: Writes to a running channel do not change its output until the counter wraps from the period value to 0. All three fields are then applied together for the next PWM cycle.
- R7: With synchronous mode off, raising the run input starts the channel at count 0, and the output shows count 0 from the next cycle.
- R8: With synchronous mode on, raising the run input arms the channel. The channel starts at count 0 on the cycle after a rising edge of the external start input is seen while it is armed. An edge that comes while the channel is stopped is ignored.
- R9: Dropping the run input stops the channel from the next cycle and clears its counter, so a restart begins at count 0.
- R10: Writes and run control addressed to one channel leave the other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_sel | input | 2 | Field select: 0 period, 1 duty, 2 polarity, 3 none |
| wr_data | input | 16 | Write data |
| ch_tick | input | 2 | Per-channel counting clock enable |
| ch_run | input | 2 | Per-channel run control, high to run |
| ch_sync | input | 2 | Per-channel synchronous-start mode select |
| ext_start | input | 1 | External start input; its rising edge starts armed channels |
| pwm_out | output | 2 | PWM outputs, one bit per channel |

## Verification
The bench sweeps duty against period, including duty zero, duty above the period and a zero period. A counter with an off-by-one wrap or compare would give the wrong number of active cycles per period. A mid-cycle change of duty and then polarity is checked sample by sample. A design that applied running writes at once would show an active or inverted level before the wrap. The synchronous start is tested with an edge given while the channel is stopped and then with one given while it is armed. A design that latched the early edge, or started without waiting, would leave its inactive level too soon. Clock-enable gating, stop and restart, and the ignored select code round out the corner cases.

// File: rtl/pwm_pkg.sv
// Package: shared encodings for the dual PWM block.
// Assumes: the write select field is two bits wide.
package pwm_pkg;

    localparam int DEF_CNT_W = 16;

    // Field select codes of the register write port
    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_POL    = 2'd2,
        SEL_NONE   = 2'd3
    } pwm_sel_e;

    // Channel run state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_edge_detect.sv
// Module: pwm_edge_detect
// Flags one cycle when the start input goes from low to high between two clocks.
// Assumes: the input is already synchronous to clk.
module pwm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    // Keep the previous sample of the start input
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    // A rise is a high input whose last sample was low
    assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/pwm_settings.sv
// Module: pwm_settings
// Holds one channel's shadow and live settings. The shadow copy takes every
// write. The live copy follows it at once while the channel is not counting,
// and only at a cycle wrap while it is counting.
// Assumes: the wrap flag is high only while the channel is running.
module pwm_settings #(
    parameter int CNT_W = pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             running,
    input  logic             wrap,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             pol_o
);
    import pwm_pkg::*;

    logic [CNT_W-1:0] sh_period_q, sh_duty_q;
    logic             sh_pol_q;
    logic [CNT_W-1:0] sh_period_d, sh_duty_d;
    logic             sh_pol_d;
    logic [CNT_W-1:0] live_period_q, live_duty_q;
    logic             live_pol_q;
    logic             load_live;

    // Merge this cycle's write into the shadow copy
    always_comb begin
        sh_period_d = sh_period_q;
        sh_duty_d   = sh_duty_q;
        sh_pol_d    = sh_pol_q;
        if (wr_hit) begin
            case (pwm_sel_e'(wr_sel))
                SEL_PERIOD: sh_period_d = wr_data;
                SEL_DUTY:   sh_duty_d   = wr_data;
                SEL_POL:    sh_pol_d    = wr_data[0];
                default:    ;
            endcase
        end
    end

    // The live copy loads when stopped or at a cycle boundary
    assign load_live = !running || wrap;

    // Register the shadow and live copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period_q   <= '0;
            sh_duty_q     <= '0;
            sh_pol_q      <= 1'b0;
            live_period_q <= '0;
            live_duty_q   <= '0;
            live_pol_q    <= 1'b0;
        end else begin
            sh_period_q <= sh_period_d;
            sh_duty_q   <= sh_duty_d;
            sh_pol_q    <= sh_pol_d;
            if (load_live) begin
                live_period_q <= sh_period_d;
                live_duty_q   <= sh_duty_d;
                live_pol_q    <= sh_pol_d;
            end
        end
    end

    assign period_o = live_period_q;
    assign duty_o   = live_duty_q;
    assign pol_o    = live_pol_q;

endmodule

// File: rtl/pwm_channel_core.sv
// Module: pwm_channel_core
// Run-state machine, counter and output level for one channel.
// Assumes: the live settings change only while stopped or on a wrap.
module pwm_channel_core #(
    parameter int CNT_W = pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             sync_mode,
    input  logic             start_rise,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             pol,
    output logic             running_o,
    output logic             armed_o,
    output logic             wrap_o,
    output logic             pwm_o
);
    import pwm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pwm_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // End of the PWM cycle: the count has reached the period
    assign at_end = (cnt_q >= period);
    assign wrap_o = (state_q == ST_RUN) && run && tick && at_end;

    // Step the run state and the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (run) state_q <= sync_mode ? ST_ARMED : ST_RUN;
                end
                ST_ARMED: begin
                    cnt_q <= '0;
                    if (!run)           state_q <= ST_IDLE;
                    else if (start_rise) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (!run) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        cnt_q <= at_end ? '0 : cnt_q + CNT_ONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign running_o = (state_q == ST_RUN);
    assign armed_o   = (state_q == ST_ARMED);

    // Active level while the count is under duty, inverted by polarity
    always_comb begin
        if (state_q == ST_RUN) pwm_o = (cnt_q < duty) ^ pol;
        else                   pwm_o = pol;
    end

endmodule

// File: rtl/pwm_dual.sv
// Module: pwm_dual (top)
// Two PWM channels that share one register write port and one external
// start input. Each channel has its own clock enable, run and sync controls.
// Assumes: all inputs are synchronous to clk.
module pwm_dual #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = pwm_pkg::DEF_CNT_W,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] ch_tick,
    input  logic [NUM_CH-1:0] ch_run,
    input  logic [NUM_CH-1:0] ch_sync,
    input  logic              ext_start,
    output logic [NUM_CH-1:0] pwm_out
);

    logic              ext_rise;
    logic [NUM_CH-1:0] chan_running;
    logic [NUM_CH-1:0] chan_armed;
    logic [NUM_CH-1:0] chan_wrap;

    pwm_edge_detect u_start_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ext_start),
        .rise_o (ext_rise)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CNT_W-1:0] period_w, duty_w;
        logic             pol_w;
        logic             hit_w;

        // Decode the channel number of the write
        assign hit_w = wr_en && (wr_ch == CH_W'(g));

        pwm_settings #(.CNT_W(CNT_W)) u_settings (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit_w),
            .wr_sel   (wr_sel),
            .wr_data  (wr_data),
            .running  (chan_running[g]),
            .wrap     (chan_wrap[g]),
            .period_o (period_w),
            .duty_o   (duty_w),
            .pol_o    (pol_w)
        );

        pwm_channel_core #(.CNT_W(CNT_W)) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (ch_tick[g]),
            .run        (ch_run[g]),
            .sync_mode  (ch_sync[g]),
            .start_rise (ext_rise),
            .period     (period_w),
            .duty       (duty_w),
            .pol        (pol_w),
            .running_o  (chan_running[g]),
            .armed_o    (chan_armed[g]),
            .wrap_o     (chan_wrap[g]),
            .pwm_o      (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_dual_checker.sv
// Module: pwm_dual_checker
// Temporal checks on the run control and outputs, bound into pwm_dual.
module pwm_dual_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_tick,
    input logic [NUM_CH-1:0] ch_run,
    input logic [NUM_CH-1:0] ch_sync,
    input logic              ext_rise,
    input logic [NUM_CH-1:0] running,
    input logic [NUM_CH-1:0] armed,
    input logic [NUM_CH-1:0] pwm_out
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ch_run[i]) |-> !running[i]); // R9

        AST_ASYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
            (!running[i] && !armed[i] && ch_run[i] && !ch_sync[i]) |=> running[i]); // R7

        AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
            (armed[i] && ch_run[i] && !ext_rise) |=> !running[i]); // R8

        AST_ARMED_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (armed[i] && ch_run[i] && ext_rise) |=> running[i]); // R8

        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (running[i] && ch_run[i] && !ch_tick[i]) |=> $stable(pwm_out[i])); // R4
    end

endmodule

bind pwm_dual pwm_dual_checker #(.NUM_CH(NUM_CH)) u_pwm_dual_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_tick  (ch_tick),
    .ch_run   (ch_run),
    .ch_sync  (ch_sync),
    .ext_rise (ext_rise),
    .running  (chan_running),
    .armed    (chan_armed),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_dual_bench.sv
// Bench for pwm_dual: a table sweep of duty against period, then directed tests.
module pwm_dual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_ch = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  ch_tick = 2'b00;
    logic [1:0]  ch_run = 2'b00;
    logic [1:0]  ch_sync = 2'b00;
    logic        ext_start = 1'b0;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    // Sweep vectors: period, duty, polarity, expected active cycles per PWM cycle
    localparam int NV = 8;
    localparam int VP[NV]   = '{4, 4, 4, 4, 0, 7, 3, 9};
    localparam int VD[NV]   = '{2, 0, 5, 9, 1, 3, 3, 1};
    localparam int VPOL[NV] = '{0, 0, 0, 0, 0, 1, 0, 1};
    localparam int VEXP[NV] = '{2, 0, 5, 5, 1, 3, 3, 1};

    always #10 clk = ~clk;

    pwm_dual u_pwm_dual (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ch_tick   (ch_tick),
        .ch_run    (ch_run),
        .ch_sync   (ch_sync),
        .ext_start (ext_start),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One-cycle write; returns at the negedge after it took effect
    task automatic wr(input int ch, input int sel, input int data);
        wr_en   = 1'b1;
        wr_ch   = 1'(ch);
        wr_sel  = 2'(sel);
        wr_data = 16'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset outputs", int'(pwm_out), 0);
        ch_tick = 2'b11;
        ch_run[0] = 1'b1;
        step();
        step();
        chk("R1 zero settings give inactive", int'(pwm_out[0]), 0);
        ch_run[0] = 1'b0;
        step();

        // Table sweep on channel 0
        for (int i = 0; i < NV; i++) begin
            int n;
            int first;
            wr(0, 0, VP[i]);
            wr(0, 1, VD[i]);
            wr(0, 2, VPOL[i]);
            chk("R2 stopped level equals polarity", int'(pwm_out[0]), VPOL[i]);
            ch_run[0] = 1'b1;
            step();
            n = 0;
            for (int k = 0; k <= VP[i]; k++) begin
                if (int'(pwm_out[0]) != VPOL[i]) n++;
                step();
            end
            chk((VD[i] == 0 || VD[i] > VP[i]) ? "R5 active count" : "R4 active count", n, VEXP[i]);
            first = (VD[i] > 0) ? 1 - VPOL[i] : VPOL[i];
            chk("R4 level after wrap", int'(pwm_out[0]), first);
            ch_run[0] = 1'b0;
            step();
        end

        // Clock-enable gating
        wr(0, 0, 4);
        wr(0, 1, 1);
        wr(0, 2, 0);
        ch_tick[0] = 1'b0;
        ch_run[0] = 1'b1;
        repeat (7) step();
        chk("R4 no count without tick", int'(pwm_out[0]), 1);
        ch_tick[0] = 1'b1;
        step();
        chk("R4 count with tick", int'(pwm_out[0]), 0);
        ch_run[0] = 1'b0;
        step();

        // Deferred update while running: period 3, duty 1, active high
        wr(0, 0, 3);
        wr(0, 1, 1);
        ch_run[0] = 1'b1;
        step();
        chk("R7 start at count 0", int'(pwm_out[0]), 1);
        wr(0, 1, 3);
        chk("R6 duty held mid cycle", int'(pwm_out[0]), 0);
        wr(0, 2, 1);
        chk("R6 polarity held mid cycle", int'(pwm_out[0]), 0);
        step();
        chk("R6 old settings to cycle end", int'(pwm_out[0]), 0);
        step();
        chk("R6 new cycle uses new duty and polarity c0", int'(pwm_out[0]), 0);
        step();
        step();
        chk("R6 new cycle c2 active low", int'(pwm_out[0]), 0);
        step();
        chk("R6 new cycle c3 inactive", int'(pwm_out[0]), 1);
        step();
        step();

        // Stop and restart
        ch_run[0] = 1'b0;
        step();
        chk("R9 stopped next cycle", int'(pwm_out[0]), 1);
        ch_run[0] = 1'b1;
        step();
        chk("R9 restart at count 0", int'(pwm_out[0]), 0);
        repeat (3) step();
        chk("R9 restart reaches count 3", int'(pwm_out[0]), 1);
        ch_run[0] = 1'b0;
        step();

        // Immediate write when stopped, ignored select code
        wr(0, 2, 0);
        chk("R3 stopped write immediate", int'(pwm_out[0]), 0);
        wr(0, 3, 16'hFFFF);
        ch_run[0] = 1'b1;
        step();
        repeat (3) step();
        chk("R3 select 3 leaves duty", int'(pwm_out[0]), 0);
        ch_run[0] = 1'b0;
        step();

        // Channel independence
        wr(1, 2, 1);
        chk("R10 channel 1 write only", int'(pwm_out), 2);

        // Synchronous start on channel 1: period 5, duty 2, active low
        wr(1, 0, 5);
        wr(1, 1, 2);
        ch_sync[1] = 1'b1;
        ext_start = 1'b1;
        step();
        ext_start = 1'b0;
        step();
        ch_run[1] = 1'b1;
        repeat (4) step();
        chk("R8 armed ignores earlier edge", int'(pwm_out[1]), 1);
        chk("R2 armed shows inactive", int'(pwm_out[1]), 1);
        ext_start = 1'b1;
        step();
        chk("R8 start after edge", int'(pwm_out[1]), 0);
        step();
        chk("R8 count 1", int'(pwm_out[1]), 0);
        step();
        chk("R8 count 2 inactive", int'(pwm_out[1]), 1);
        chk("R10 channel 0 untouched", int'(pwm_out[0]), 0);

        finish_run();
    end

endmodule